// File: doc/BRIEF.md
# Serial Receive Byte Deserializer

This block is the digital receive back end of a USB-style transceiver. It takes an already recovered line stream, one symbol per bit-strobe, and produces a byte-wide receive interface. The interface carries a data byte, a packet-active flag, a byte-valid flag and an error flag. It finds the start-of-packet synchronisation pattern, undoes NRZI coding, removes the zero bits the transmitter inserted, packs the remaining bits into bytes least-significant bit first, and hides the end-of-packet marker from the byte side. Clock recovery, squelch, the analog front end and CRC checking are outside the block.

The outputs are registered and change only in cycles where `byte_stb_o` is high. `byte_stb_o` acts as the byte-clock enable that the link samples on. While a packet is in progress, one strobe occurs for every eight line bits. Because removed stuff bits still take line time, the assembled data falls behind the line. After eight removed bits, one byte slot has no byte in it. The receiver then follows the same framing for short packets without CRC as for long ones, and goes back to searching for the next packet as soon as a packet ends.

Top module: `utmi_rx_deser`

## Requirements
- R1: While `rst_ni` is low and after reset release with an idle line, `rx_active_o`, `rx_valid_o`, `rx_error_o`, `byte_stb_o` and `data_o` are all 0.
- R2: Line symbols are encoded on `line_i` as 2'b10 = J, 2'b01 = K, 2'b00 = SE0, 2'b11 = treated as SE0. NRZI decodes a repeated symbol as 1 and a change as 0. The synchronisation pattern is at least three decoded 0s followed by a 1 whose symbol is K (two K's in a row). It raises `rx_active_o` with `rx_valid_o` low in a strobe cycle, within 43 bit strobes of the pattern's first K. Transitions that do not end in two K's raise nothing.
- R3: Data bits are packed least-significant bit first. `data_o` carries a received byte only in strobe cycles with `rx_valid_o` high, and `rx_valid_o` is never high without `rx_active_o`.
- R4: After six consecutive decoded 1s (the final 1 of the synchronisation pattern counts), the next decoded 0 is removed and is not placed into any byte.
- R5: During a packet a byte slot strobe occurs every eight line bits, stuffed bits included. A slot carries the byte that completed within it, and `rx_valid_o` is low in a slot with no completed byte. Eight removed stuff bits therefore cost one byte slot with `rx_valid_o` low.
- R6: An SE0 symbol ends the packet. If a completed byte has not yet been presented, one extra strobe presents it. The next strobe lowers `rx_active_o` and `rx_valid_o` together, and no end-of-packet marker ever appears as data.
- R7: Bits of an incomplete byte at the end of a packet are discarded and raise no `rx_valid_o`.
- R8: A seventh consecutive decoded 1 is a stuffing violation. It raises `rx_error_o` for one cycle with `rx_valid_o` low. The following cycle lowers `rx_active_o`, and no further bytes of that packet are delivered.
- R9: After a packet ends or is aborted, the block returns to searching, and a following packet is received in full.
- R10: Outputs hold their values in every cycle where `byte_stb_o` is low. Idle cycles between bit strobes do not change the received bytes or the slot framing.
- R11: A one-byte packet with no CRC is framed like a longer packet: an announce strobe, a valid byte, then the strobe that drops the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | High for one cycle when `line_i` holds a new line symbol |
| line_i | input | 2 | Recovered line symbol (J, K, SE0) |
| data_o | output | 8 | Received byte |
| rx_active_o | output | 1 | Packet in progress |
| rx_valid_o | output | 1 | `data_o` holds a byte in this slot |
| rx_error_o | output | 1 | Stuffing violation, one cycle |
| byte_stb_o | output | 1 | Byte-clock enable: outputs update in these cycles |

## Verification
A stale ones counter shows as a stuffed zero left inside a byte, or as a false error. Either shows on `data_o` or `rx_error_o` in the slot after the bit in question, at most eight line bits later. A slot counter that is off shifts which strobe carries each byte, so valid-low slots appear in packets without enough stuffing, or no slot is skipped after eight removed bits. A lost pending flag drops the last byte at end of packet. A state machine that fails to re-arm shows as a missing announce strobe for the next packet.

// File: rtl/utmi_rx_pkg.sv
package utmi_rx_pkg;
  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_K   = 2'b01,
    SYM_J   = 2'b10,
    SYM_SE1 = 2'b11
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_PKT   = 2'd1,
    ST_CLOSE = 2'd2
  } rx_state_e;
endpackage

// File: rtl/utmi_rx_nrzi.sv
module utmi_rx_nrzi
  import utmi_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic [1:0] line_i,
  output logic       se0_o,
  output logic       is_k_o,
  output logic       bit_o,
  output logic       strobe_o
);
  logic prev_k_q;

  assign se0_o    = (line_i == SYM_SE0) || (line_i == SYM_SE1);
  assign is_k_o   = (line_i == SYM_K);
  assign bit_o    = (is_k_o == prev_k_q);
  assign strobe_o = bit_en_i && !se0_o;

  // line idles at J; SE0 returns the reference level to J
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_k_q <= 1'b0;
    else if (bit_en_i) prev_k_q <= se0_o ? 1'b0 : is_k_o;
  end
endmodule

// File: rtl/utmi_rx_unstuff.sv
module utmi_rx_unstuff #(
  parameter int RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  input  logic bit_i,
  output logic drop_o,
  output logic viol_o
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(RUN);

  logic [CW-1:0] ones_q;

  assign drop_o = en_i && (ones_q == RUN_C) && !bit_i;
  assign viol_o = en_i && (ones_q == RUN_C) && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ones_q <= '0;
    else if (load_i) ones_q <= CW'(1);
    else if (en_i) begin
      if (!bit_i)               ones_q <= '0;
      else if (ones_q != RUN_C) ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/utmi_rx_pack.sv
module utmi_rx_pack #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         raw_en_i,
  input  logic         dat_en_i,
  input  logic         bit_i,
  output logic         tick_o,
  output logic         avail_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  shift_q, hold_q, new_byte;
  logic [CW-1:0] dcnt_q, slot_q;
  logic          pend_q, done_now;

  assign new_byte = {bit_i, shift_q[W-1:1]};
  assign done_now = dat_en_i && (dcnt_q == LAST);
  assign tick_o   = raw_en_i && (slot_q == LAST);
  assign avail_o  = pend_q || done_now;
  assign byte_o   = done_now ? new_byte : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0; hold_q <= '0; dcnt_q <= '0; slot_q <= '0; pend_q <= 1'b0;
    end else if (clear_i) begin
      shift_q <= '0; hold_q <= '0; dcnt_q <= '0; slot_q <= '0; pend_q <= 1'b0;
    end else begin
      if (raw_en_i) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      if (dat_en_i) begin
        shift_q <= new_byte;
        dcnt_q  <= (dcnt_q == LAST) ? '0 : dcnt_q + 1'b1;
      end
      if (done_now) hold_q <= new_byte;
      if (tick_o)        pend_q <= 1'b0;
      else if (done_now) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/utmi_rx_deser.sv
module utmi_rx_deser
  import utmi_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STUFF_RUN  = 6,
  parameter int SYNC_EDGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [1:0]        line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rx_active_o,
  output logic              rx_valid_o,
  output logic              rx_error_o,
  output logic              byte_stb_o
);
  localparam int ZW = $clog2(SYNC_EDGES + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(SYNC_EDGES);

  rx_state_e         state_q;
  logic [ZW-1:0]     zcnt_q;
  logic              se0, is_k, dbit, strobe;
  logic              drop, viol, tick, avail;
  logic [DATA_W-1:0] pk_byte;
  logic              start, in_pkt, pkt_bit, raw_en, dat_en, eop;

  utmi_rx_nrzi u_nrzi (
    .clk_i, .rst_ni, .bit_en_i, .line_i,
    .se0_o(se0), .is_k_o(is_k), .bit_o(dbit), .strobe_o(strobe)
  );

  assign in_pkt  = (state_q == ST_PKT);
  assign start   = (state_q == ST_HUNT) && strobe && dbit && is_k && (zcnt_q >= ZMAX);
  assign pkt_bit = in_pkt && strobe;
  assign raw_en  = pkt_bit && !viol;
  assign dat_en  = raw_en && !drop;
  assign eop     = in_pkt && bit_en_i && se0;

  utmi_rx_unstuff #(.RUN(STUFF_RUN)) u_unstuff (
    .clk_i, .rst_ni, .load_i(start), .en_i(pkt_bit), .bit_i(dbit),
    .drop_o(drop), .viol_o(viol)
  );

  utmi_rx_pack #(.W(DATA_W)) u_pack (
    .clk_i, .rst_ni, .clear_i(start), .raw_en_i(raw_en), .dat_en_i(dat_en),
    .bit_i(dbit), .tick_o(tick), .avail_o(avail), .byte_o(pk_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT; zcnt_q <= '0; data_o <= '0;
      rx_active_o <= 1'b0; rx_valid_o <= 1'b0; rx_error_o <= 1'b0; byte_stb_o <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      rx_error_o <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (bit_en_i) begin
            if (se0 || dbit)       zcnt_q <= '0;
            else if (zcnt_q != ZMAX) zcnt_q <= zcnt_q + 1'b1;
          end
          if (start) begin
            state_q <= ST_PKT; byte_stb_o <= 1'b1;
            rx_active_o <= 1'b1; rx_valid_o <= 1'b0;
          end
        end
        ST_PKT: begin
          if (eop) begin
            byte_stb_o <= 1'b1;
            if (avail) begin
              rx_valid_o <= 1'b1; data_o <= pk_byte; state_q <= ST_CLOSE;
            end else begin
              rx_active_o <= 1'b0; rx_valid_o <= 1'b0; state_q <= ST_HUNT;
            end
          end else if (pkt_bit && viol) begin
            byte_stb_o <= 1'b1; rx_error_o <= 1'b1; rx_valid_o <= 1'b0;
            state_q <= ST_CLOSE;
          end else if (tick) begin
            byte_stb_o <= 1'b1; rx_valid_o <= avail;
            if (avail) data_o <= pk_byte;
          end
        end
        default: begin
          byte_stb_o <= 1'b1; rx_active_o <= 1'b0; rx_valid_o <= 1'b0;
          zcnt_q <= '0; state_q <= ST_HUNT;
        end
      endcase
    end
  end
endmodule

// File: rtl/utmi_rx_deser_chk.sv
module utmi_rx_deser_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_en_i,
  input logic [1:0]        line_i,
  input logic [DATA_W-1:0] data_o,
  input logic              rx_active_o,
  input logic              rx_valid_o,
  input logic              rx_error_o,
  input logic              byte_stb_o
);
  p_valid_in_pkt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_active_o);
  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_error_o |=> !rx_error_o);
  p_err_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_error_o |=> (!rx_active_o && !rx_valid_o));
  p_err_no_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_error_o |-> (!rx_valid_o && rx_active_o));
  p_announce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_active_o) |-> (!rx_valid_o && byte_stb_o));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_stb_o |-> ($stable(data_o) && $stable(rx_active_o) && $stable(rx_valid_o)));
  p_drop_together_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_active_o) |-> (byte_stb_o && !rx_valid_o));
endmodule

bind utmi_rx_deser utmi_rx_deser_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_utmi_rx_deser.sv
module sim_utmi_rx_deser;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] LJ = 2'b10, LK = 2'b01, LSE0 = 2'b00;

  logic clk = 1'b0, rst_ni = 1'b0, bit_en = 1'b0;
  logic [1:0] line = LJ;
  logic [7:0] data;
  logic act, val, err, stb;

  always #(CLK_PERIOD/2) clk = ~clk;

  utmi_rx_deser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .line_i(line),
    .data_o(data), .rx_active_o(act), .rx_valid_o(val), .rx_error_o(err), .byte_stb_o(stb)
  );

  int n_tests = 0, n_fail = 0, gap = 0;
  int bits_seen = 0, rise_at = -1, n_ev = 0, n_x = 0;
  logic       ev_act [64], ev_val [64], ev_err [64];
  logic [7:0] ev_dat [64];
  logic       x_act [64], x_val [64], x_err [64];
  logic [7:0] x_dat [64];
  logic [7:0] pb [16];
  logic [1:0] lvl = LJ;

  always @(posedge clk) if (bit_en) bits_seen <= bits_seen + 1;

  always @(negedge clk) begin
    if (stb && n_ev < 64) begin
      ev_act[n_ev] = act; ev_val[n_ev] = val; ev_err[n_ev] = err; ev_dat[n_ev] = data;
      n_ev = n_ev + 1;
    end
    if (act && rise_at < 0) rise_at = bits_seen;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int actual, input int expect_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expect_v);
    end
  endtask

  task automatic put(input logic [1:0] s);
    @(negedge clk); line = s; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_dec(input logic b);
    if (!b) lvl = (lvl == LJ) ? LK : LJ;
    put(lvl);
  endtask

  task automatic clear_log();
    n_ev = 0; rise_at = -1; n_x = 0;
  endtask

  task automatic expect_ev(input logic a, input logic v, input logic e, input logic [7:0] d);
    x_act[n_x] = a; x_val[n_x] = v; x_err[n_x] = e; x_dat[n_x] = d; n_x++;
  endtask

  task automatic send_sync(output int s0);
    put(LJ); put(LJ); lvl = LJ;
    s0 = bits_seen;
    put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LK);
    lvl = LK;
  endtask

  task automatic send_eop();
    put(LSE0); put(LSE0); put(LJ); put(LJ); lvl = LJ;
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(n_ev == n_x, {req, " strobe count"}, n_ev, n_x);
    for (int i = 0; i < n_x && i < n_ev; i++) begin
      check(ev_act[i] == x_act[i], {req, " rx_active"}, int'(ev_act[i]), int'(x_act[i]));
      check(ev_val[i] == x_val[i], {req, " rx_valid"}, int'(ev_val[i]), int'(x_val[i]));
      check(ev_err[i] == x_err[i], {req, " rx_error"}, int'(ev_err[i]), int'(x_err[i]));
      if (x_val[i]) check(ev_dat[i] == x_dat[i], {req, " data"}, int'(ev_dat[i]), int'(x_dat[i]));
    end
  endtask

  // Builds the line stream from pb[0..nb-1] plus `part` trailing zero bits and the expected strobes
  task automatic send_pkt(input int nb, input int part, input string req);
    int s0, ones, raw, nc, ci, nbits;
    int cpos [16];
    logic [7:0] cbyte [16];
    logic d;
    clear_log();
    send_sync(s0);
    ones = 1; raw = 0; nc = 0; nbits = nb * 8 + part;
    for (int i = 0; i < nbits; i++) begin
      d = (i < nb * 8) ? pb[i / 8][i % 8] : 1'b0;
      send_dec(d); raw++;
      ones = d ? ones + 1 : 0;
      if ((i % 8 == 7) && (i < nb * 8)) begin cpos[nc] = raw; cbyte[nc] = pb[i / 8]; nc++; end
      if (ones == 6) begin send_dec(1'b0); raw++; ones = 0; end
    end
    send_eop();
    expect_ev(1'b1, 1'b0, 1'b0, 8'h00);
    ci = 0;
    for (int t = 8; t <= raw; t += 8) begin
      if (ci < nc && cpos[ci] <= t) begin expect_ev(1'b1, 1'b1, 1'b0, cbyte[ci]); ci++; end
      else expect_ev(1'b1, 1'b0, 1'b0, 8'h00);
    end
    if (ci < nc) expect_ev(1'b1, 1'b1, 1'b0, cbyte[ci]);
    expect_ev(1'b0, 1'b0, 1'b0, 8'h00);
    compare(req);
    check(rise_at - s0 <= 43 && rise_at - s0 >= 8, "R2 sync latency", rise_at - s0, 8);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({act, val, err, stb} == 4'b0 && data == 8'h00, "R1 outputs in reset", {act, val, err, stb}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check({act, val, err, stb} == 4'b0 && data == 8'h00, "R1 outputs after reset", {act, val, err, stb}, 0);
  endtask

  task automatic t_handshake();
    pb[0] = 8'hD2;
    send_pkt(1, 0, "R11 one byte packet");
  endtask

  task automatic t_multi();
    pb[0] = 8'hA5; pb[1] = 8'h3C; pb[2] = 8'h01; pb[3] = 8'h80;
    send_pkt(4, 0, "R3 lsb first bytes");
  endtask

  task automatic t_stuff();
    int skips;
    for (int i = 0; i < 12; i++) pb[i] = 8'hFF;
    send_pkt(12, 0, "R4 stuffed ones");
    skips = 0;
    for (int i = 1; i + 1 < n_ev; i++) if (ev_act[i] && !ev_val[i]) skips++;
    check(skips >= 1, "R5 slot skipped after eight stuff bits", skips, 1);
  endtask

  task automatic t_flush();
    pb[0] = 8'hFF; pb[1] = 8'h7E;
    send_pkt(2, 0, "R6 pending byte at eop");
    check(n_ev >= 2 && !ev_act[n_ev-1] && !ev_val[n_ev-1] && ev_val[n_ev-2],
          "R6 last byte then drop", n_ev, n_x);
  endtask

  task automatic t_partial();
    pb[0] = 8'h55; pb[1] = 8'h0F;
    send_pkt(2, 3, "R7 partial byte discarded");
  endtask

  task automatic t_violation();
    int s0;
    clear_log();
    send_sync(s0);
    for (int i = 0; i < 8; i++) send_dec(1'b0);
    for (int i = 0; i < 7; i++) send_dec(1'b1);
    send_eop();
    expect_ev(1'b1, 1'b0, 1'b0, 8'h00);
    expect_ev(1'b1, 1'b1, 1'b0, 8'h00);
    expect_ev(1'b1, 1'b0, 1'b1, 8'h00);
    expect_ev(1'b0, 1'b0, 1'b0, 8'h00);
    compare("R8 seven ones abort");
  endtask

  task automatic t_rearm();
    pb[0] = 8'h69; pb[1] = 8'h96;
    send_pkt(2, 0, "R9 first packet");
    pb[0] = 8'hC3;
    send_pkt(1, 0, "R9 packet after re-arm");
  endtask

  task automatic t_gaps();
    gap = 3;
    for (int i = 0; i < 10; i++) pb[i] = 8'hFF;
    pb[10] = 8'h12;
    send_pkt(11, 0, "R10 idle cycles between bits");
    gap = 0;
  endtask

  task automatic t_noise();
    clear_log();
    put(LJ); put(LK); put(LJ); put(LK); put(LJ); put(LJ); put(LJ);
    put(LSE0); put(LJ); put(LJ);
    repeat (4) @(negedge clk);
    check(n_ev == 0 && !act, "R2 no sync without two K", n_ev, 0);
  endtask

  initial begin
    t_reset();
    t_noise();
    t_handshake();
    t_multi();
    t_stuff();
    t_flush();
    t_partial();
    t_violation();
    t_rearm();
    t_gaps();
    summary();
    $finish;
  end
endmodule